// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block turns the instruction fields of a single-cycle 32-bit load/store processor into the control levels that steer the datapath. A first stage looks at the 6-bit primary opcode. It produces the register-destination select, the ALU operand-B select, the write-back source select, the register-file write enable, the data-memory read and write strobes, the branch-if-equal flag and a 2-bit ALU operation class. A second stage combines that class with the low four bits of the function field and produces the 3-bit ALU operation code.

Four opcodes are recognised: 0 for register-register (R-format), 35 for load word, 43 for store word and 4 for branch-if-equal. Any other opcode is treated as unsupported and leaves every control that changes machine state low. The decoded controls are captured in an output register on the rising clock edge. The register is cleared by a synchronous active-low reset, so the datapath always sees glitch-free levels that are stable for a whole cycle.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: When `rst_n` is low at a rising edge, every output is 0 after that edge.
- R2: Opcode 0 gives dst_rd=1, opb_imm=0, wb_mem=0, rf_we=1, dmem_re=0, dmem_we=0, br_eq=0 and alu_class=2'b10.
- R3: Opcode 35 gives dst_rd=0, opb_imm=1, wb_mem=1, rf_we=1, dmem_re=1, dmem_we=0, br_eq=0, alu_class=2'b00 and alu_fn=3'b010 (add).
- R4: Opcode 43 gives opb_imm=1, dmem_we=1, rf_we=0, dmem_re=0, br_eq=0, dst_rd=0, wb_mem=0, alu_class=2'b00 and alu_fn=3'b010.
- R5: Opcode 4 gives br_eq=1, opb_imm=0, rf_we=0, dmem_re=0, dmem_we=0, dst_rd=0, wb_mem=0, alu_class=2'b01 and alu_fn=3'b110 (subtract).
- R6: Any other opcode drives all outputs to 0, except alu_fn, which is 3'b010.
- R7: With opcode 0, the low funct nibble selects alu_fn as follows: 4'b0000 gives 3'b010 (add), 4'b0010 gives 3'b110 (sub), 4'b0100 gives 3'b000 (and), 4'b0101 gives 3'b001 (or) and 4'b1010 gives 3'b111 (set-on-less-than).
- R8: funct bits [5:4] have no effect on any output.
- R9: With opcode 0 and a low funct nibble not listed in R7, alu_fn is 3'b010.
- R10: For every opcode other than 0, the funct field has no effect on any output.
- R11: Outputs reflect the opcode and funct present at a rising edge after that edge, and they hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field of R-format instructions |
| dst_rd | output | 1 | Write register taken from the rd field (else rt) |
| opb_imm | output | 1 | ALU operand B is the sign-extended immediate |
| wb_mem | output | 1 | Write-back data comes from data memory |
| rf_we | output | 1 | Register-file write enable |
| dmem_re | output | 1 | Data-memory read strobe |
| dmem_we | output | 1 | Data-memory write strobe |
| br_eq | output | 1 | Branch-if-equal flag |
| alu_class | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by funct |
| alu_fn | output | 3 | ALU operation code |

## Verification
Every result is due exactly one rising edge after its inputs are applied: the inputs go in on a falling edge, and the output register captures them on the next rising edge. The scoreboard pushes one expected vector for each falling edge at which it drives. The monitor pops that vector a short delay after the following rising edge and compares it. This keeps each comparison tied to the single register stage, whether the vector is a reset vector or a decode vector. Back-to-back changes of opcode and funct show that each result reflects only the inputs from its own cycle.

// File: rtl/scd_pkg.sv
// Package: shared widths, opcode values, class and ALU code encodings
// for the single-cycle control decoder. Assumes a 6-bit opcode and a
// 6-bit funct field, of which only the low four funct bits matter.
package scd_pkg;
    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int FN_USED = 4;
    localparam int CLS_W   = 2;
    localparam int ALU_W   = 3;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'd0;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OP_W-1:0] OPC_STORE = 6'd43;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;

    localparam logic [CLS_W-1:0] CLS_ADD   = 2'b00;
    localparam logic [CLS_W-1:0] CLS_SUB   = 2'b01;
    localparam logic [CLS_W-1:0] CLS_FUNCT = 2'b10;

    localparam logic [ALU_W-1:0] ALU_AND = 3'b000;
    localparam logic [ALU_W-1:0] ALU_OR  = 3'b001;
    localparam logic [ALU_W-1:0] ALU_ADD = 3'b010;
    localparam logic [ALU_W-1:0] ALU_SUB = 3'b110;
    localparam logic [ALU_W-1:0] ALU_SLT = 3'b111;

    localparam logic [FN_USED-1:0] FN_ADD = 4'b0000;
    localparam logic [FN_USED-1:0] FN_SUB = 4'b0010;
    localparam logic [FN_USED-1:0] FN_AND = 4'b0100;
    localparam logic [FN_USED-1:0] FN_OR  = 4'b0101;
    localparam logic [FN_USED-1:0] FN_SLT = 4'b1010;

    typedef struct packed {
        logic             dst_rd;
        logic             opb_imm;
        logic             wb_mem;
        logic             rf_we;
        logic             dmem_re;
        logic             dmem_we;
        logic             br_eq;
        logic [CLS_W-1:0] alu_class;
    } main_ctl_t;
endpackage

// File: rtl/scd_main_dec.sv
// Module: first decode level. Maps the primary opcode to the datapath
// controls and the ALU class. Purely combinational. Assumes unknown
// opcodes must leave every state-changing control low.
module scd_main_dec
    import scd_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output main_ctl_t       ctl,
    output logic            op_known
);
    // Opcode lookup: one arm per recognised instruction, safe default otherwise.
    always_comb begin
        ctl       = '0;
        ctl.alu_class = CLS_ADD;
        op_known  = 1'b1;
        case (opcode)
            OPC_RTYPE: begin
                ctl.dst_rd    = 1'b1;
                ctl.rf_we     = 1'b1;
                ctl.alu_class = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctl.opb_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.rf_we   = 1'b1;
                ctl.dmem_re = 1'b1;
            end
            OPC_STORE: begin
                ctl.opb_imm = 1'b1;
                ctl.dmem_we = 1'b1;
            end
            OPC_BEQ: begin
                ctl.br_eq     = 1'b1;
                ctl.alu_class = CLS_SUB;
            end
            default: op_known = 1'b0;
        endcase
    end
endmodule

// File: rtl/scd_alu_dec.sv
// Module: second decode level. Combines the ALU class with the low
// funct nibble into the 3-bit ALU code. Purely combinational. Assumes
// funct bits above FN_USED carry no information.
module scd_alu_dec
    import scd_pkg::*;
(
    input  logic [CLS_W-1:0]   alu_class,
    input  logic [FN_USED-1:0] fn_lo,
    output logic [ALU_W-1:0]   alu_fn
);
    // Class select first, then funct nibble lookup for register ops.
    always_comb begin
        alu_fn = ALU_ADD;
        case (alu_class)
            CLS_SUB:   alu_fn = ALU_SUB;
            CLS_FUNCT: begin
                case (fn_lo)
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_ADD;
                endcase
            end
            default:   alu_fn = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_ctrl_decoder.sv
// Module: top of the control decoder. Chains the two decode levels and
// registers their results once per clock. Assumes opcode/funct are
// stable around the rising edge; reset is synchronous, active low.
module sc_ctrl_decoder
    import scd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output logic            dst_rd,
    output logic            opb_imm,
    output logic            wb_mem,
    output logic            rf_we,
    output logic            dmem_re,
    output logic            dmem_we,
    output logic            br_eq,
    output logic [CLS_W-1:0] alu_class,
    output logic [ALU_W-1:0] alu_fn
);
    main_ctl_t        ctl_d, ctl_q;
    logic             op_known;
    logic [ALU_W-1:0] fn_d, fn_q;

    scd_main_dec u_main (
        .opcode   (opcode),
        .ctl      (ctl_d),
        .op_known (op_known)
    );

    scd_alu_dec u_alu (
        .alu_class (ctl_d.alu_class),
        .fn_lo     (funct[FN_USED-1:0]),
        .alu_fn    (fn_d)
    );

    // Output register: one stage between the decode and the datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            fn_q  <= '0;
        end else begin
            ctl_q <= ctl_d;
            fn_q  <= fn_d;
        end
    end

    assign dst_rd    = ctl_q.dst_rd;
    assign opb_imm   = ctl_q.opb_imm;
    assign wb_mem    = ctl_q.wb_mem;
    assign rf_we     = ctl_q.rf_we;
    assign dmem_re   = ctl_q.dmem_re;
    assign dmem_we   = ctl_q.dmem_we;
    assign br_eq     = ctl_q.br_eq;
    assign alu_class = ctl_q.alu_class;
    assign alu_fn    = fn_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == '0 && fn_q == '0));

    // R6
    unknown_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_known |=> (!rf_we && !dmem_re && !dmem_we && !br_eq));

    // R3
    load_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |-> (wb_mem && rf_we && !dmem_we));

    // R4
    store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (!rf_we && !dmem_re && opb_imm));

    // R5
    beq_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_eq |-> (alu_fn == ALU_SUB && !rf_we && !opb_imm));

    // R7
    slt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_RTYPE && funct == 6'b101010) |=> alu_fn == ALU_SLT);
endmodule

// File: tb/sim_sc_ctrl_decoder.sv
module sim_sc_ctrl_decoder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       dst_rd, opb_imm, wb_mem, rf_we, dmem_re, dmem_we, br_eq;
    logic [1:0] alu_class;
    logic [2:0] alu_fn;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_ctrl_decoder u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
        .dst_rd(dst_rd), .opb_imm(opb_imm), .wb_mem(wb_mem), .rf_we(rf_we),
        .dmem_re(dmem_re), .dmem_we(dmem_we), .br_eq(br_eq),
        .alu_class(alu_class), .alu_fn(alu_fn)
    );

    // Expected vector {dst,imm,wbm,rfwe,re,we,br,class[1:0],fn[2:0]}
    function automatic logic [11:0] model(input logic [5:0] op, input logic [5:0] fn);
        logic [2:0] a;
        case (fn[3:0])
            4'b0010: a = 3'b110;
            4'b0100: a = 3'b000;
            4'b0101: a = 3'b001;
            4'b1010: a = 3'b111;
            default: a = 3'b010;
        endcase
        case (op)
            6'd0:  return {7'b1001000, 2'b10, a};
            6'd35: return {7'b0111100, 2'b00, 3'b010};
            6'd43: return {7'b0100010, 2'b00, 3'b010};
            6'd4:  return {7'b0000001, 2'b01, 3'b110};
            default: return {7'b0000000, 2'b00, 3'b010};
        endcase
    endfunction

    // Driver: apply on a falling edge, push the expected result (R11: due after next rising edge)
    task automatic apply(input logic r, input logic [5:0] op, input logic [5:0] fn, input string tag);
        @(negedge clk);
        rst_n  = r;
        opcode = op;
        funct  = fn;
        exp_q.push_back(r ? model(op, fn) : 12'd0);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one item shortly after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0 && !done) begin
            logic [11:0] e, g;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            g = {dst_rd, opb_imm, wb_mem, rf_we, dmem_re, dmem_we, br_eq, alu_class, alu_fn};
            total++;
            if (g !== e) begin
                bad++;
                $display("FAIL %s actual=%b expected=%b", t, g, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with live inputs still clears everything
        apply(1'b0, 6'd35, 6'h2a, "R1");
        apply(1'b0, 6'd0, 6'h20, "R1");
        // R2 / R7: register-format operations
        apply(1'b1, 6'd0, 6'b100000, "R2_R7 add");
        apply(1'b1, 6'd0, 6'b100010, "R7 sub");
        apply(1'b1, 6'd0, 6'b100100, "R7 and");
        apply(1'b1, 6'd0, 6'b100101, "R7 or");
        apply(1'b1, 6'd0, 6'b101010, "R7 slt");
        // R8: upper funct bits changed, same nibble
        apply(1'b1, 6'd0, 6'b011010, "R8 slt");
        apply(1'b1, 6'd0, 6'b000100, "R8 and");
        apply(1'b1, 6'd0, 6'b110101, "R8 or");
        apply(1'b1, 6'd0, 6'b010010, "R8 sub");
        // R9: unlisted nibbles fall back to add
        for (int n = 0; n < 16; n++) apply(1'b1, 6'd0, {2'b10, 4'(n)}, "R9_R7 nibble");
        // R3 / R4 / R5 with differing funct (R10)
        apply(1'b1, 6'd35, 6'b101010, "R3");
        apply(1'b1, 6'd43, 6'b100010, "R4");
        apply(1'b1, 6'd4, 6'b100101, "R5");
        apply(1'b1, 6'd35, 6'b000000, "R10 load");
        apply(1'b1, 6'd43, 6'b111111, "R10 store");
        apply(1'b1, 6'd4, 6'b100100, "R10 beq");
        // R6: unsupported opcodes
        apply(1'b1, 6'd2, 6'b101010, "R6");
        apply(1'b1, 6'd63, 6'b100010, "R6");
        apply(1'b1, 6'd36, 6'b100000, "R6");
        // R10 / R6: sweep every opcode with several funct values
        for (int o = 0; o < 64; o++) begin
            apply(1'b1, 6'(o), 6'b101010, "R10 sweep");
            apply(1'b1, 6'(o), 6'b000101, "R10 sweep");
        end
        // R1: reset mid-stream, then R11 back-to-back change
        apply(1'b0, 6'd0, 6'b101010, "R1 mid");
        apply(1'b1, 6'd43, 6'b0, "R11 store");
        apply(1'b1, 6'd35, 6'b0, "R11 load");
        apply(1'b1, 6'd4, 6'b0, "R11 beq");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule